// File: doc/BRIEF.md
# Parallel Port Direction Turnaround and Reverse Receiver

This block decides which side may drive a bidirectional 8-bit parallel data bus, and it receives bytes sent by the peripheral while the bus runs in reverse. When software raises a level request, the block first turns off the host data drivers. One cycle later it pulls the direction line low. It then waits for the peripheral to pull its reverse-acknowledge line low. After that acknowledge the link is in reverse, and the block moves bytes with an interlocked two-wire handshake. Each byte goes into a receive FIFO together with the one-bit command/data tag carried on the peripheral's busy line.

When the request drops, the block releases the direction line. It drives the data bus again only after the peripheral raises the reverse-acknowledge line. If the peripheral does not answer a turnaround within a set number of cycles, the block raises a sticky error flag and falls back to forward idle. Flow control is done by holding off the host acknowledge. While the FIFO is full, the host does not signal ready, so the peripheral cannot start another byte.

Peripheral inputs pass through a synchronizer of `SYNC_STAGES` flops. All pin outputs are registered.

Top module: `pport_turnaround`

## Requirements
- R1: After reset the block is in forward idle with `hostDataOe`=1, `dirReqN`=1, `hostAck`=0, `revActive`=0, `turnErr`=0 and `rxValid`=0.
- R2: A rise of `reverseReq` in forward idle drops `hostDataOe` two cycles later. `dirReqN` goes low one cycle after that, so the drivers are never on while reverse is requested.
- R3: Reverse mode is entered only after `ackRevN` is seen low through the synchronizer. `revActive` rises `SYNC_STAGES`+2 cycles after `ackRevN` falls. In reverse idle `hostAck` is low (ready) and `hostDataOe` stays low.
- R4: In reverse idle with room in the FIFO, a low `dataValidN` stores {`periphTag`,`busIn`} into the FIFO `SYNC_STAGES`+1 cycles later, and `hostAck` goes high one cycle after that. `hostAck` returns low `SYNC_STAGES`+2 cycles after `dataValidN` rises. Each low pulse stores exactly one entry.
- R5: The FIFO holds `FIFO_DEPTH` (16) entries in arrival order. `rxData`/`rxTag` show the oldest entry while `rxValid` is high. `rxPop` removes that entry at the next edge. `rxPop` while empty has no effect.
- R6: While the FIFO is full, `hostAck` stays high after a handshake completes. It goes low two cycles after the cycle in which `rxPop` is presented.
- R7: A fall of `reverseReq` in reverse idle raises `dirReqN` two cycles later. `hostDataOe` stays low until `ackRevN` is seen high, and rises `SYNC_STAGES`+2 cycles after `ackRevN` rises.
- R8: If the peripheral does not answer within `TURN_TIMEOUT` cycles of the direction line changing, `turnErr` rises. The block returns to forward idle (`dirReqN`=1, `hostDataOe`=1) and starts no new turnaround until `reverseReq` is low, which clears `turnErr` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reverseReq | input | 1 | Software level: 1 asks for reverse, 0 for forward |
| ackRevN | input | 1 | Peripheral reverse acknowledge, low = reverse granted |
| dataValidN | input | 1 | Peripheral data strobe in reverse, low = byte valid |
| periphTag | input | 1 | Command/data tag on the busy line during reverse |
| busIn | input | 8 | Data bus as seen by the receiver |
| rxPop | input | 1 | Remove the FIFO head |
| hostDataOe | output | 1 | Host data driver enable |
| dirReqN | output | 1 | Direction line, low = reverse requested |
| hostAck | output | 1 | Host acknowledge, high = byte taken or FIFO full |
| revActive | output | 1 | Link is in reverse data transfer |
| turnErr | output | 1 | Sticky turnaround timeout flag |
| rxValid | output | 1 | FIFO is not empty |
| rxData | output | 8 | FIFO head data |
| rxTag | output | 1 | FIFO head tag |

## Verification
Every result depends on a known number of register stages. Software-side results take two cycles, one for the state register and one for the pin register. Peripheral-side results take `SYNC_STAGES`+2 cycles, and FIFO contents show one cycle earlier than `hostAck`. The bench drives inputs on the falling edge, waits the exact number of rising edges, and samples on the next falling edge. It checks each boundary twice: once a cycle before the change is due, to see the old value, and once in the cycle it is due. A scoreboard queue, filled by the peripheral driver and drained by a monitor, checks FIFO order and tags no matter when entries are popped.

// File: rtl/pport_turn_pkg.sv
package pport_turn_pkg;

  typedef enum logic [2:0] {
    ST_FWD_IDLE = 3'd0,
    ST_DRV_OFF  = 3'd1,
    ST_REV_WAIT = 3'd2,
    ST_REV_IDLE = 3'd3,
    ST_REV_HELD = 3'd4,
    ST_FWD_WAIT = 3'd5
  } turnState_e;

  // Control-to-datapath strobes
  typedef struct packed {
    logic push;       // store current bus byte and tag
    logic driveOn;    // host drivers may be on
    logic dirRev;     // direction line asserted
    logic hostAckHi;  // host acknowledge high
    logic revMode;    // reverse transfer state
  } turnStrobe_t;

endpackage

// File: rtl/pport_turn_ctrl.sv
module pport_turn_ctrl
  import pport_turn_pkg::*;
#(
  parameter int TURN_TIMEOUT = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reverseReq,
  input  logic        ackRevNSync,
  input  logic        dataValidNSync,
  input  logic        fifoFull,
  output turnStrobe_t strobes,
  output logic        turnErr
);

  localparam int CW = $clog2(TURN_TIMEOUT + 1);

  turnState_e state, stateNext;
  logic [CW-1:0] waitCnt;
  logic timedOut;
  logic errSet;

  assign timedOut = (waitCnt == CW'(TURN_TIMEOUT - 1));

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_FWD_IDLE: if (reverseReq && !turnErr) stateNext = ST_DRV_OFF;
      ST_DRV_OFF:  stateNext = ST_REV_WAIT;
      ST_REV_WAIT: begin
        if (!ackRevNSync)  stateNext = ST_REV_IDLE;
        else if (timedOut) stateNext = ST_FWD_IDLE;
      end
      ST_REV_IDLE: begin
        if (!reverseReq)                      stateNext = ST_FWD_WAIT;
        else if (!dataValidNSync && !fifoFull) stateNext = ST_REV_HELD;
      end
      ST_REV_HELD: begin
        if (dataValidNSync) stateNext = reverseReq ? ST_REV_IDLE : ST_FWD_WAIT;
      end
      ST_FWD_WAIT: begin
        if (ackRevNSync || timedOut) stateNext = ST_FWD_IDLE;
      end
      default: stateNext = ST_FWD_IDLE;
    endcase
  end

  assign errSet = timedOut &&
                  (((state == ST_REV_WAIT) && ackRevNSync) ||
                   ((state == ST_FWD_WAIT) && !ackRevNSync));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_FWD_IDLE;
      waitCnt <= '0;
      turnErr <= 1'b0;
    end else begin
      state <= stateNext;
      if (stateNext != state)             waitCnt <= '0;
      else if (waitCnt != CW'(TURN_TIMEOUT)) waitCnt <= waitCnt + 1'b1;
      if (errSet)
        turnErr <= 1'b1;
      else if ((state == ST_FWD_IDLE) && !reverseReq)
        turnErr <= 1'b0;
    end
  end

  always_comb begin
    strobes.push      = (state == ST_REV_IDLE) && (stateNext == ST_REV_HELD);
    strobes.driveOn   = (state == ST_FWD_IDLE);
    strobes.dirRev    = (state == ST_REV_WAIT) || (state == ST_REV_IDLE) ||
                        (state == ST_REV_HELD);
    strobes.hostAckHi = (state == ST_REV_HELD) ||
                        ((state == ST_REV_IDLE) && fifoFull);
    strobes.revMode   = (state == ST_REV_IDLE) || (state == ST_REV_HELD);
  end

  // R8: a raised error flag always coincides with forward idle
  a_r8_err_holds_forward: assert property (@(posedge clk) disable iff (!rstN)
    turnErr |-> (state == ST_FWD_IDLE));

  // R4: one capture per handshake, never on consecutive cycles
  a_r4_single_push: assert property (@(posedge clk) disable iff (!rstN)
    strobes.push |=> !strobes.push);

endmodule

// File: rtl/pport_turn_dpath.sv
module pport_turn_dpath
  import pport_turn_pkg::*;
#(
  parameter int FIFO_DEPTH  = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  turnStrobe_t       strobes,
  input  logic              ackRevNIn,
  input  logic              dataValidNIn,
  input  logic              tagIn,
  input  logic [DATA_W-1:0] busIn,
  input  logic              rxPop,
  output logic              ackRevNSync,
  output logic              dataValidNSync,
  output logic              fifoFull,
  output logic              rxValid,
  output logic [DATA_W-1:0] rxData,
  output logic              rxTag,
  output logic              hostDataOe,
  output logic              dirReqN,
  output logic              hostAck,
  output logic              revActive
);

  localparam int AW = $clog2(FIFO_DEPTH);
  localparam int EW = DATA_W + 1;

  // Input synchronizer: bit 1 = ack-reverse, bit 0 = data valid
  logic [SYNC_STAGES-1:0][1:0] syncQ;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rstN) syncQ[s] <= 2'b11;
        else       syncQ[s] <= {ackRevNIn, dataValidNIn};
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rstN) syncQ[s] <= 2'b11;
        else       syncQ[s] <= syncQ[s-1];
      end
    end
  end

  assign ackRevNSync    = syncQ[SYNC_STAGES-1][1];
  assign dataValidNSync = syncQ[SYNC_STAGES-1][0];

  // Receive FIFO
  logic [EW-1:0] mem [FIFO_DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [AW:0]   count;
  logic          popDo;

  assign fifoFull = (count == (AW+1)'(FIFO_DEPTH));
  assign rxValid  = (count != '0);
  assign popDo    = rxPop && rxValid;
  assign rxData   = mem[rdPtr][DATA_W-1:0];
  assign rxTag    = mem[rdPtr][DATA_W];

  always_ff @(posedge clk) begin
    if (strobes.push) mem[wrPtr] <= {tagIn, busIn};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strobes.push)
        wrPtr <= (wrPtr == AW'(FIFO_DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (popDo)
        rdPtr <= (rdPtr == AW'(FIFO_DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      unique case ({strobes.push, popDo})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // Registered pin outputs
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostDataOe <= 1'b1;
      dirReqN    <= 1'b1;
      hostAck    <= 1'b0;
      revActive  <= 1'b0;
    end else begin
      hostDataOe <= strobes.driveOn;
      dirReqN    <= !strobes.dirRev;
      hostAck    <= strobes.hostAckHi;
      revActive  <= strobes.revMode;
    end
  end

  // R2: drivers are off whenever reverse is requested on the pin
  a_r2_no_drive_in_reverse: assert property (@(posedge clk) disable iff (!rstN)
    !dirReqN |-> !hostDataOe);

  // R6: a capture never lands in a full FIFO
  a_r6_no_push_when_full: assert property (@(posedge clk) disable iff (!rstN)
    strobes.push |-> !fifoFull);

  // R5: occupancy stays within depth
  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    count <= (AW+1)'(FIFO_DEPTH));

endmodule

// File: rtl/pport_turnaround.sv
module pport_turnaround
  import pport_turn_pkg::*;
#(
  parameter int FIFO_DEPTH   = 16,
  parameter int SYNC_STAGES  = 2,
  parameter int TURN_TIMEOUT = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reverseReq,
  input  logic       ackRevN,
  input  logic       dataValidN,
  input  logic       periphTag,
  input  logic [7:0] busIn,
  input  logic       rxPop,
  output logic       hostDataOe,
  output logic       dirReqN,
  output logic       hostAck,
  output logic       revActive,
  output logic       turnErr,
  output logic       rxValid,
  output logic [7:0] rxData,
  output logic       rxTag
);

  turnStrobe_t strobes;
  logic ackRevNSync;
  logic dataValidNSync;
  logic fifoFull;

  pport_turn_ctrl #(
    .TURN_TIMEOUT(TURN_TIMEOUT)
  ) ctrl_i (
    .clk           (clk),
    .rstN          (rstN),
    .reverseReq    (reverseReq),
    .ackRevNSync   (ackRevNSync),
    .dataValidNSync(dataValidNSync),
    .fifoFull      (fifoFull),
    .strobes       (strobes),
    .turnErr       (turnErr)
  );

  pport_turn_dpath #(
    .FIFO_DEPTH (FIFO_DEPTH),
    .DATA_W     (8),
    .SYNC_STAGES(SYNC_STAGES)
  ) dpath_i (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .ackRevNIn     (ackRevN),
    .dataValidNIn  (dataValidN),
    .tagIn         (periphTag),
    .busIn         (busIn),
    .rxPop         (rxPop),
    .ackRevNSync   (ackRevNSync),
    .dataValidNSync(dataValidNSync),
    .fifoFull      (fifoFull),
    .rxValid       (rxValid),
    .rxData        (rxData),
    .rxTag         (rxTag),
    .hostDataOe    (hostDataOe),
    .dirReqN       (dirReqN),
    .hostAck       (hostAck),
    .revActive     (revActive)
  );

  // R7: drivers come back only once the peripheral has released the bus
  a_r7_oe_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(hostDataOe) && !turnErr) |-> ackRevNSync);

endmodule

// File: tb/pport_turnaround_tb_top.sv
module pport_turnaround_tb_top;

  localparam int DEPTH = 16;
  localparam int SYNC  = 2;
  localparam int TO    = 12;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reverseReq = 1'b0;
  logic       ackRevN = 1'b1;
  logic       dataValidN = 1'b1;
  logic       periphTag = 1'b0;
  logic [7:0] busIn = 8'h00;
  logic       rxPop = 1'b0;
  logic       hostDataOe, dirReqN, hostAck, revActive, turnErr, rxValid, rxTag;
  logic [7:0] rxData;

  int checks = 0;
  int failures = 0;
  bit drainOn = 1'b0;
  bit popReq = 1'b0;
  bit done = 1'b0;
  logic [8:0] expQ[$];

  pport_turnaround #(
    .FIFO_DEPTH(DEPTH), .SYNC_STAGES(SYNC), .TURN_TIMEOUT(TO)
  ) dut_i (
    .clk(clk), .rstN(rstN), .reverseReq(reverseReq), .ackRevN(ackRevN),
    .dataValidN(dataValidN), .periphTag(periphTag), .busIn(busIn),
    .rxPop(rxPop), .hostDataOe(hostDataOe), .dirReqN(dirReqN),
    .hostAck(hostAck), .revActive(revActive), .turnErr(turnErr),
    .rxValid(rxValid), .rxData(rxData), .rxTag(rxTag)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Peripheral driver: one full reverse byte handshake
  task automatic sendByte(input logic [7:0] data, input logic tag);
    int guard;
    guard = 0;
    while (hostAck && guard < 40) begin @(negedge clk); guard++; end
    check(!hostAck, "R4", "host ready before byte", hostAck, 0);
    busIn = data; periphTag = tag; dataValidN = 1'b0;
    expQ.push_back({tag, data});
    guard = 0;
    while (!hostAck && guard < 40) begin @(negedge clk); guard++; end
    check(hostAck, "R4", "host-ack raised after byte", hostAck, 1);
    dataValidN = 1'b1;
    edges(1);
  endtask

  // Monitor: pops FIFO head and compares with scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && (drainOn || popReq)) begin
        popReq = 1'b0;
        rxPop  = 1'b1;
        if (rxValid) begin
          if (expQ.size() == 0) begin
            check(1'b0, "R5", "unexpected FIFO entry", {rxTag, rxData}, 0);
          end else begin
            logic [8:0] e;
            e = expQ.pop_front();
            check({rxTag, rxData} == e, "R5", "FIFO head tag/data",
                  {rxTag, rxData}, e);
          end
        end
      end else begin
        rxPop = 1'b0;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      @(negedge clk);
      check(1'b0, "WATCHDOG", "run did not finish", 0, 1);
      finishRun();
    end
  end

  initial begin
    int guard;
    edges(3);
    rstN = 1'b1;
    edges(1);

    // R1: reset state
    check(hostDataOe == 1'b1, "R1", "oe after reset", hostDataOe, 1);
    check(dirReqN == 1'b1, "R1", "dirReqN after reset", dirReqN, 1);
    check(hostAck == 1'b0, "R1", "hostAck after reset", hostAck, 0);
    check(revActive == 1'b0, "R1", "revActive after reset", revActive, 0);
    check(turnErr == 1'b0, "R1", "turnErr after reset", turnErr, 0);
    check(rxValid == 1'b0, "R1", "rxValid after reset", rxValid, 0);

    // R5: pop while empty is ignored
    @(posedge clk); popReq = 1'b1;
    @(negedge clk);
    edges(2);
    check(rxValid == 1'b0, "R5", "pop on empty leaves FIFO empty", rxValid, 0);

    // R2: reverse entry ordering
    reverseReq = 1'b1;
    edges(1);
    check(hostDataOe == 1'b1, "R2", "oe one cycle after request", hostDataOe, 1);
    edges(1);
    check(hostDataOe == 1'b0, "R2", "oe off two cycles after request", hostDataOe, 0);
    check(dirReqN == 1'b1, "R2", "dirReqN still high with oe off", dirReqN, 1);
    edges(1);
    check(dirReqN == 1'b0, "R2", "dirReqN low three cycles after request", dirReqN, 0);

    // R3: reverse only after acknowledge
    edges(2);
    check(revActive == 1'b0, "R3", "no reverse without ack", revActive, 0);
    ackRevN = 1'b0;
    edges(SYNC + 1);
    check(revActive == 1'b0, "R3", "revActive one cycle before due", revActive, 0);
    edges(1);
    check(revActive == 1'b1, "R3", "revActive after ack", revActive, 1);
    check(hostAck == 1'b0, "R3", "host ready in reverse idle", hostAck, 0);
    check(hostDataOe == 1'b0, "R3", "oe off in reverse", hostDataOe, 0);

    // R4: first byte with exact timing
    busIn = 8'hA5; periphTag = 1'b1; dataValidN = 1'b0;
    expQ.push_back({1'b1, 8'hA5});
    edges(SYNC);
    check(rxValid == 1'b0, "R4", "no capture before sync", rxValid, 0);
    edges(1);
    check(rxValid == 1'b1, "R4", "byte stored", rxValid, 1);
    check(rxData == 8'hA5, "R4", "stored data", rxData, 8'hA5);
    check(rxTag == 1'b1, "R4", "stored tag", rxTag, 1);
    check(hostAck == 1'b0, "R4", "hostAck one cycle before raise", hostAck, 0);
    edges(1);
    check(hostAck == 1'b1, "R4", "hostAck raised", hostAck, 1);
    dataValidN = 1'b1;
    edges(SYNC + 1);
    check(hostAck == 1'b1, "R4", "hostAck still high before due", hostAck, 1);
    edges(1);
    check(hostAck == 1'b0, "R4", "hostAck lowered after strobe release", hostAck, 0);

    // R6: fill the FIFO
    for (int i = 1; i < DEPTH; i++) sendByte(8'h10 + 8'(i), i[0]);
    edges(8);
    check(hostAck == 1'b1, "R6", "hostAck held while full", hostAck, 1);
    @(posedge clk); popReq = 1'b1;
    @(negedge clk);
    edges(1);
    check(hostAck == 1'b1, "R6", "hostAck one cycle after pop", hostAck, 1);
    edges(1);
    check(hostAck == 1'b0, "R6", "hostAck lowered after pop", hostAck, 0);

    // R5: drain with more traffic
    drainOn = 1'b1;
    sendByte(8'h3C, 1'b0);
    sendByte(8'hC3, 1'b1);
    sendByte(8'hFF, 1'b1);
    sendByte(8'h00, 1'b0);
    guard = 0;
    while ((expQ.size() != 0 || rxValid) && guard < 200) begin @(negedge clk); guard++; end
    check(expQ.size() == 0, "R5", "scoreboard drained", expQ.size(), 0);
    drainOn = 1'b0;
    edges(1);

    // R7: forward return
    reverseReq = 1'b0;
    edges(2);
    check(dirReqN == 1'b1, "R7", "dirReqN released", dirReqN, 1);
    check(hostDataOe == 1'b0, "R7", "oe still off", hostDataOe, 0);
    check(revActive == 1'b0, "R7", "reverse left", revActive, 0);
    edges(3);
    check(hostDataOe == 1'b0, "R7", "oe off until ack high", hostDataOe, 0);
    ackRevN = 1'b1;
    edges(SYNC + 1);
    check(hostDataOe == 1'b0, "R7", "oe one cycle before due", hostDataOe, 0);
    edges(1);
    check(hostDataOe == 1'b1, "R7", "oe back on", hostDataOe, 1);
    check(turnErr == 1'b0, "R7", "no error on clean return", turnErr, 0);

    // R8: timeout
    reverseReq = 1'b1;
    edges(TO + 1);
    check(dirReqN == 1'b0, "R8", "still waiting before timeout", dirReqN, 0);
    check(turnErr == 1'b0, "R8", "no error before timeout", turnErr, 0);
    edges(2);
    check(turnErr == 1'b1, "R8", "error after timeout", turnErr, 1);
    check(dirReqN == 1'b1, "R8", "direction released on timeout", dirReqN, 1);
    check(hostDataOe == 1'b1, "R8", "oe on after timeout", hostDataOe, 1);
    edges(10);
    check(dirReqN == 1'b1, "R8", "no restart while error", dirReqN, 1);
    check(turnErr == 1'b1, "R8", "error sticky", turnErr, 1);
    reverseReq = 1'b0;
    edges(1);
    check(turnErr == 1'b0, "R8", "error cleared by dropping request", turnErr, 0);

    done = 1'b1;
    finishRun();
  end

endmodule